// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one router node of a two-dimensional mesh network. It has four neighbour links (North, South, East, West) and a local port that carries traffic to and from the attached processing element. It stores no packets. Each flit that arrives on a neighbour link is held for exactly one cycle in a pipeline register. In the next cycle it leaves on some output: its preferred link, the local ejection port, or any other free link. When two flits compete for one link, the loser is deflected rather than queued.

Routing follows dimension order: X is corrected first, then Y. An age field in every flit sets the arbitration order, so the oldest flit chooses first. The age grows on every hop, which keeps any flit from circling forever. The local element may inject a new flit only in a cycle where an available link is still unclaimed after all transit flits have been placed. The router's own coordinates and the mesh size are parameters. A router on the mesh boundary never drives a link that has no neighbour behind it.

Top module: `defl_router`

## Requirements
- R1: After a synchronous active-high reset, no output link and no ejection port reports a valid flit.
- R2: A flit presented on a neighbour input before clock edge k leaves after edge k+1. Every such flit appears on exactly one output (a link or the ejection port), so the number of flits leaving equals the number that entered plus the accepted injection.
- R3: A flit is laid out as {dst_x, dst_y, age, payload} from MSB to LSB. Port indices are North=0 (y+1), South=1 (y-1), East=2 (x+1) and West=3 (x-1). The productive port is East if dst_x > own x, West if dst_x < own x, else North if dst_y > own y, else South. An uncontended flit leaves on its productive port.
- R4: Flits are placed one at a time. A higher age goes first. On equal ages the lower input index goes first. A flit placed earlier wins a contested port.
- R5: A flit whose productive port is already taken leaves on the lowest-numbered available port that is still free.
- R6: A flit whose destination equals the router's coordinates leaves on the ejection port, at most one per cycle. A further such flit in the same cycle is deflected as in R5.
- R7: inj_ready is high exactly when at least one available link is left free after all transit flits are placed. An accepted injected flit takes its productive port if free, else the lowest free available port. It never uses the ejection port.
- R8: A flit leaving on a link carries its age plus one, saturating at the field maximum. An ejected flit keeps its age unchanged. Coordinates and payload are never changed.
- R9: A router on the mesh edge never asserts a valid flit on a link that has no neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 4 | Valid per neighbour input (N,S,E,W) |
| rx_flit | input | 4 x FW | Flit per neighbour input |
| inj_valid | input | 1 | Local element offers a flit |
| inj_flit | input | FW | Flit offered for injection |
| inj_ready | output | 1 | Injection accepted this cycle when inj_valid is high |
| tx_valid | output | 4 | Valid per neighbour output (N,S,E,W) |
| tx_flit | output | 4 x FW | Flit per neighbour output |
| ej_valid | output | 1 | Flit delivered to the local element |
| ej_flit | output | FW | Delivered flit |

## Verification
The bound checker checks four things on every cycle: flit conservation across the two-edge pass, silence on links with no neighbour, the destination of every ejected flit, and that a refused injection means every available link is full in the next cycle. It cannot show which flit wins a contested port, which port a loser is sent to, or the age arithmetic. The bench scenarios show those by comparing every output link against a reference placement. That reference is built from the age order, the index tie-break and the lowest-free rule, in directed contention cases and in random traffic on an interior node and a corner node.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int N_MESH = 4;
  localparam logic [1:0] P_N = 2'd0;
  localparam logic [1:0] P_S = 2'd1;
  localparam logic [1:0] P_E = 2'd2;
  localparam logic [1:0] P_W = 2'd3;
endpackage

// File: rtl/defl_dir_sel.sv
module defl_dir_sel import defl_pkg::*; #(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 1,
  parameter int MY_Y = 1
) (
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  output logic [1:0]     dir,
  output logic           here
);
  localparam logic [X_W-1:0] HX = X_W'(MY_X);
  localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

  always_comb begin
    here = (dst_x == HX) && (dst_y == HY);
    if (dst_x > HX)      dir = P_E;
    else if (dst_x < HX) dir = P_W;
    else if (dst_y > HY) dir = P_N;
    else                 dir = P_S;
  end
endmodule

// File: rtl/defl_rank.sv
module defl_rank #(
  parameter int N     = 4,
  parameter int AGE_W = 4,
  parameter int RW    = $clog2(N)
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][AGE_W-1:0] age,
  output logic [N-1:0][RW-1:0]    rank
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j != i && vld[j] &&
            ((age[j] > age[i]) || ((age[j] == age[i]) && (j < i))))
          rank[i] = rank[i] + RW'(1);
      end
    end
  end
endmodule

// File: rtl/defl_alloc.sv
module defl_alloc #(
  parameter int N  = 4,
  parameter int RW = $clog2(N),
  parameter int SW = $clog2(N+1)
) (
  input  logic [N-1:0]          req_v,
  input  logic [N-1:0][RW-1:0]  rank,
  input  logic [N-1:0][RW-1:0]  want,
  input  logic [N-1:0]          here,
  input  logic [N-1:0]          avail,
  input  logic                  inj_v,
  input  logic [RW-1:0]         inj_want,
  input  logic                  inj_here,
  output logic [N-1:0]          grant_v,
  output logic [N-1:0][SW-1:0]  grant_src,
  output logic                  ej_v,
  output logic [RW-1:0]         ej_src,
  output logic                  inj_ready
);
  logic [N-1:0] busy;
  logic         placed;

  always_comb begin
    busy      = '0;
    grant_src = '0;
    ej_v      = 1'b0;
    ej_src    = '0;
    placed    = 1'b0;
    for (int r = 0; r < N; r++) begin
      for (int i = 0; i < N; i++) begin
        if (req_v[i] && rank[i] == RW'(r)) begin
          placed = 1'b0;
          if (here[i] && !ej_v) begin
            ej_v   = 1'b1;
            ej_src = RW'(i);
            placed = 1'b1;
          end else if (!here[i] && avail[want[i]] && !busy[want[i]]) begin
            busy[want[i]]      = 1'b1;
            grant_src[want[i]] = SW'(i);
            placed             = 1'b1;
          end
          for (int p = 0; p < N; p++) begin
            if (!placed && avail[p] && !busy[p]) begin
              busy[p]      = 1'b1;
              grant_src[p] = SW'(i);
              placed       = 1'b1;
            end
          end
        end
      end
    end
    inj_ready = |(avail & ~busy);
    if (inj_v && inj_ready) begin
      placed = 1'b0;
      if (!inj_here && avail[inj_want] && !busy[inj_want]) begin
        busy[inj_want]      = 1'b1;
        grant_src[inj_want] = SW'(N);
        placed              = 1'b1;
      end
      for (int p = 0; p < N; p++) begin
        if (!placed && avail[p] && !busy[p]) begin
          busy[p]      = 1'b1;
          grant_src[p] = SW'(N);
          placed       = 1'b1;
        end
      end
    end
    grant_v = busy;
  end
endmodule

// File: rtl/defl_router.sv
module defl_router import defl_pkg::*; #(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int AGE_W  = 4,
  parameter int DATA_W = 16,
  parameter int COLS   = 4,
  parameter int ROWS   = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 1,
  localparam int FW    = X_W + Y_W + AGE_W + DATA_W,
  localparam int NP    = N_MESH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NP-1:0]          rx_valid,
  input  logic [NP-1:0][FW-1:0]  rx_flit,
  input  logic                   inj_valid,
  input  logic [FW-1:0]          inj_flit,
  output logic                   inj_ready,
  output logic [NP-1:0]          tx_valid,
  output logic [NP-1:0][FW-1:0]  tx_flit,
  output logic                   ej_valid,
  output logic [FW-1:0]          ej_flit
);
  localparam int RW = $clog2(NP);
  localparam int SW = $clog2(NP + 1);
  localparam int CW = X_W + Y_W;
  localparam logic [NP-1:0] AVAIL = {(MY_X > 0), (MY_X < COLS - 1),
                                     (MY_Y > 0), (MY_Y < ROWS - 1)};

  logic [NP-1:0]            lat_v;
  logic [NP-1:0][FW-1:0]    lat_f;
  logic [NP-1:0][RW-1:0]    want;
  logic [NP-1:0]            here;
  logic [NP-1:0][AGE_W-1:0] age;
  logic [NP-1:0][RW-1:0]    rank;
  logic [RW-1:0]            inj_want;
  logic                     inj_here;
  logic [NP-1:0]            grant_v;
  logic [NP-1:0][SW-1:0]    grant_src;
  logic                     alloc_ej;
  logic [RW-1:0]            alloc_ej_src;
  logic [NP-1:0][FW-1:0]    next_f;

  always_ff @(posedge clk) begin
    if (rst) lat_v <= '0;
    else     lat_v <= rx_valid;
    lat_f <= rx_flit;
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign age[i] = lat_f[i][DATA_W +: AGE_W];
    defl_dir_sel #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_dir (
      .dst_x (lat_f[i][FW-1 -: X_W]),
      .dst_y (lat_f[i][FW-X_W-1 -: Y_W]),
      .dir   (want[i]),
      .here  (here[i])
    );
  end

  defl_dir_sel #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_inj_dir (
    .dst_x (inj_flit[FW-1 -: X_W]),
    .dst_y (inj_flit[FW-X_W-1 -: Y_W]),
    .dir   (inj_want),
    .here  (inj_here)
  );

  defl_rank #(.N(NP), .AGE_W(AGE_W)) u_rank (
    .vld  (lat_v),
    .age  (age),
    .rank (rank)
  );

  defl_alloc #(.N(NP)) u_alloc (
    .req_v     (lat_v),
    .rank      (rank),
    .want      (want),
    .here      (here),
    .avail     (AVAIL),
    .inj_v     (inj_valid),
    .inj_want  (inj_want),
    .inj_here  (inj_here),
    .grant_v   (grant_v),
    .grant_src (grant_src),
    .ej_v      (alloc_ej),
    .ej_src    (alloc_ej_src),
    .inj_ready (inj_ready)
  );

  for (genvar p = 0; p < NP; p++) begin : g_out
    logic [FW-1:0]    pick;
    logic [AGE_W-1:0] a_old;
    logic [AGE_W-1:0] a_new;
    assign pick  = (grant_src[p] == SW'(NP)) ? inj_flit
                                             : lat_f[grant_src[p][RW-1:0]];
    assign a_old = pick[DATA_W +: AGE_W];
    assign a_new = (&a_old) ? a_old : a_old + AGE_W'(1);
    assign next_f[p] = {pick[FW-1 -: CW], a_new, pick[DATA_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= '0;
      ej_valid <= 1'b0;
    end else begin
      tx_valid <= grant_v;
      ej_valid <= alloc_ej;
    end
    tx_flit <= next_f;
    ej_flit <= lat_f[alloc_ej_src];
  end
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk #(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int MY_X = 1,
  parameter int MY_Y = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [3:0]           rx_valid,
  input logic                 inj_valid,
  input logic                 inj_ready,
  input logic [3:0]           tx_valid,
  input logic                 ej_valid,
  input logic [X_W+Y_W-1:0]   ej_dst
);
  localparam logic [3:0] LINKS = {(MY_X != 0), (MY_X != COLS - 1),
                                  (MY_Y != 0), (MY_Y != ROWS - 1)};
  localparam logic [X_W+Y_W-1:0] SELF = {X_W'(MY_X), Y_W'(MY_Y)};

  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst)                live <= 2'd0;
    else if (live != 2'd3)  live <= live + 2'd1;
  end

  assert_conserve_R2: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd3) |->
      ($countones(tx_valid) + 32'(ej_valid) ==
       $past($countones(rx_valid), 2) + 32'($past(inj_valid && inj_ready))));

  assert_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid & ~LINKS) == 4'd0);

  assert_eject_R6: assert property (@(posedge clk) disable iff (rst)
    ej_valid |-> (ej_dst == SELF));

  assert_inj_block_R7: assert property (@(posedge clk) disable iff (rst)
    !inj_ready |=> (tx_valid == LINKS));
endmodule

bind defl_router defl_router_chk #(
  .X_W(X_W), .Y_W(Y_W), .COLS(COLS), .ROWS(ROWS), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_valid  (rx_valid),
  .inj_valid (inj_valid),
  .inj_ready (inj_ready),
  .tx_valid  (tx_valid),
  .ej_valid  (ej_valid),
  .ej_dst    (ej_flit[X_W+Y_W+AGE_W+DATA_W-1 -: X_W+Y_W])
);

// File: tb/defl_router_test.sv
`timescale 1ns/1ps
module defl_router_test;
  localparam int XW = 3, YW = 3, AW = 4, DW = 16;
  localparam int FW = XW + YW + AW + DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]          a_rv, c_rv, a_tv, c_tv;
  logic [3:0][FW-1:0]  a_rf, c_rf, a_tf, c_tf;
  logic                a_jv, c_jv, a_jr, c_jr, a_ev, c_ev;
  logic [FW-1:0]       a_jf, c_jf, a_ef, c_ef;

  int n_chk = 0;
  int n_fail = 0;

  defl_router #(.X_W(XW), .Y_W(YW), .AGE_W(AW), .DATA_W(DW), .COLS(4), .ROWS(4),
                .MY_X(1), .MY_Y(1)) uut (
    .clk(clk), .rst(rst), .rx_valid(a_rv), .rx_flit(a_rf), .inj_valid(a_jv),
    .inj_flit(a_jf), .inj_ready(a_jr), .tx_valid(a_tv), .tx_flit(a_tf),
    .ej_valid(a_ev), .ej_flit(a_ef));

  defl_router #(.X_W(XW), .Y_W(YW), .AGE_W(AW), .DATA_W(DW), .COLS(4), .ROWS(4),
                .MY_X(0), .MY_Y(0)) uut_corner (
    .clk(clk), .rst(rst), .rx_valid(c_rv), .rx_flit(c_rf), .inj_valid(c_jv),
    .inj_flit(c_jf), .inj_ready(c_jr), .tx_valid(c_tv), .tx_flit(c_tf),
    .ej_valid(c_ev), .ej_flit(c_ef));

  function automatic logic [FW-1:0] mk(int x, int y, int ag, int pay);
    return {XW'(x), YW'(y), AW'(ag), DW'(pay)};
  endfunction

  function automatic int f_age(logic [FW-1:0] f);
    return int'(f[DW +: AW]);
  endfunction

  function automatic int goal(int mx, int my, logic [FW-1:0] f);
    int dx = int'(f[FW-1 -: XW]);
    int dy = int'(f[FW-XW-1 -: YW]);
    if (dx > mx) return 2;
    if (dx < mx) return 3;
    if (dy > my) return 0;
    if (dy < my) return 1;
    return 4;
  endfunction

  function automatic logic [FW-1:0] hop(logic [FW-1:0] f);
    logic [FW-1:0] g = f;
    if (f_age(f) != (1 << AW) - 1) g[DW +: AW] = f[DW +: AW] + AW'(1);
    return g;
  endfunction

  task automatic model(input int mx, input int my, input logic [3:0] av,
                       input logic [3:0] iv, input logic [3:0][FW-1:0] ifl,
                       input logic jv, input logic [FW-1:0] jf,
                       output logic [3:0] ov, output logic [3:0][FW-1:0] of,
                       output logic ev, output logic [FW-1:0] ef, output logic rdy);
    logic [3:0] done = 4'd0;
    ov = '0; of = '0; ev = 1'b0; ef = '0;
    for (int k = 0; k < 4; k++) begin
      int best = -1;
      for (int i = 0; i < 4; i++)
        if (iv[i] && !done[i] && (best < 0 || f_age(ifl[i]) > f_age(ifl[best]))) best = i;
      if (best >= 0) begin
        int w = goal(mx, my, ifl[best]);
        bit ok = 1'b0;
        done[best] = 1'b1;
        if (w == 4 && !ev) begin ev = 1'b1; ef = ifl[best]; ok = 1'b1; end
        else if (w < 4 && !ov[w]) begin ov[w] = 1'b1; of[w] = hop(ifl[best]); ok = 1'b1; end
        for (int p = 0; p < 4; p++)
          if (!ok && av[p] && !ov[p]) begin ov[p] = 1'b1; of[p] = hop(ifl[best]); ok = 1'b1; end
      end
    end
    rdy = |(av & ~ov);
    if (jv && rdy) begin
      int w = goal(mx, my, jf);
      bit ok = 1'b0;
      if (w < 4 && !ov[w]) begin ov[w] = 1'b1; of[w] = hop(jf); ok = 1'b1; end
      for (int p = 0; p < 4; p++)
        if (!ok && av[p] && !ov[p]) begin ov[p] = 1'b1; of[p] = hop(jf); ok = 1'b1; end
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic txn(input int which, input string tag, input logic [3:0] iv,
                     input logic [3:0][FW-1:0] ifl, input logic jv, input logic [FW-1:0] jf);
    logic [3:0] ov; logic [3:0][FW-1:0] of; logic ev, rdy; logic [FW-1:0] ef;
    int mx = (which == 0) ? 1 : 0;
    logic [3:0] av = (which == 0) ? 4'b1111 : 4'b0101;
    model(mx, mx, av, iv, ifl, jv, jf, ov, of, ev, ef, rdy);
    @(negedge clk);
    if (which == 0) begin a_rv = iv; a_rf = ifl; end
    else            begin c_rv = iv; c_rf = ifl; end
    @(negedge clk);
    a_rv = '0; c_rv = '0;
    check(((which == 0) ? a_jr : c_jr) == rdy, tag, "inj_ready",
          64'((which == 0) ? a_jr : c_jr), 64'(rdy));
    if (which == 0) begin a_jv = jv; a_jf = jf; end
    else            begin c_jv = jv; c_jf = jf; end
    @(negedge clk);
    a_jv = 1'b0; c_jv = 1'b0;
    for (int p = 0; p < 4; p++) begin
      logic v = (which == 0) ? a_tv[p] : c_tv[p];
      logic [FW-1:0] f = (which == 0) ? a_tf[p] : c_tf[p];
      check(v == ov[p] && (!ov[p] || f == of[p]), tag, $sformatf("link %0d", p),
            {v, 32'(f)}, {ov[p], 32'(of[p])});
    end
    begin
      logic v = (which == 0) ? a_ev : c_ev;
      logic [FW-1:0] f = (which == 0) ? a_ef : c_ef;
      check(v == ev && (!ev || f == ef), tag, "eject", {v, 32'(f)}, {ev, 32'(ef)});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0][FW-1:0] fl;
    int seed = 1234;
    void'($urandom(seed));
    a_rv = '0; c_rv = '0; a_rf = '0; c_rf = '0;
    a_jv = 1'b0; c_jv = 1'b0; a_jf = '0; c_jf = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(a_tv == 4'd0 && a_ev == 1'b0, "R1", "reset outputs", 64'({a_tv, a_ev}), 64'd0);
    check(c_tv == 4'd0 && c_ev == 1'b0, "R1", "reset corner", 64'({c_tv, c_ev}), 64'd0);

    // R3: four flits, four distinct productive ports, X before Y
    fl[0] = mk(1, 0, 3, 16'h1111); fl[1] = mk(3, 1, 3, 16'h2222);
    fl[2] = mk(0, 2, 3, 16'h3333); fl[3] = mk(1, 3, 3, 16'h4444);
    txn(0, "R3", 4'b1111, fl, 1'b0, '0);
    // R4: all want East, ages differ, tie S vs E
    fl[0] = mk(3, 1, 5, 1); fl[1] = mk(2, 0, 9, 2); fl[2] = mk(3, 3, 9, 3); fl[3] = mk(2, 2, 2, 4);
    txn(0, "R4", 4'b1111, fl, 1'b0, '0);
    // R5: equal ages, losers take lowest free ports
    fl[0] = mk(0, 1, 7, 5); fl[1] = mk(0, 2, 7, 6); fl[2] = mk(0, 0, 7, 7); fl[3] = mk(1, 0, 1, 8);
    txn(0, "R5", 4'b1110, fl, 1'b0, '0);
    // R6: two flits for this node, one ejects, the other deflects
    fl[0] = mk(1, 1, 4, 9); fl[1] = mk(1, 1, 6, 10); fl[2] = mk(3, 3, 2, 11); fl[3] = mk(0, 0, 1, 12);
    txn(0, "R6", 4'b1111, fl, 1'b0, '0);
    // R7: full links block injection; an ejecting flit frees a link
    fl[0] = mk(2, 2, 1, 13); fl[1] = mk(2, 2, 1, 14); fl[2] = mk(0, 1, 1, 15); fl[3] = mk(2, 1, 1, 16);
    txn(0, "R7", 4'b1111, fl, 1'b1, mk(3, 3, 0, 17));
    fl[0] = mk(1, 1, 1, 18);
    txn(0, "R7", 4'b1111, fl, 1'b1, mk(3, 3, 0, 19));
    // R8: age saturates on a hop, ejection keeps age
    fl[0] = mk(1, 3, 15, 20); fl[1] = mk(1, 1, 15, 21); fl[2] = mk(0, 1, 14, 22); fl[3] = '0;
    txn(0, "R8", 4'b0111, fl, 1'b0, '0);
    // R9: corner node, both flits want East, loser goes North only
    fl = '0; fl[0] = mk(3, 0, 2, 23); fl[2] = mk(2, 0, 2, 24);
    txn(1, "R9", 4'b0101, fl, 1'b1, mk(1, 2, 0, 25));

    for (int n = 0; n < 400; n++) begin
      int which = n % 2;
      int mx = (which == 0) ? 1 : 0;
      logic [3:0] iv = 4'($urandom) & ((which == 0) ? 4'b1111 : 4'b0101);
      logic jv = 1'($urandom);
      logic [FW-1:0] jf;
      int jx, jy;
      for (int i = 0; i < 4; i++)
        fl[i] = mk($urandom % 4, $urandom % 4, $urandom % 16, $urandom);
      do begin jx = $urandom % 4; jy = $urandom % 4; end while (jx == mx && jy == mx);
      jf = mk(jx, jy, $urandom % 16, $urandom);
      txn(which, "R2", iv, fl, jv, jf);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule